// File: doc/BRIEF.md
# Write-Completion Status Readback

This block builds the byte a host sees when it reads a byte-alterable non-volatile memory. While the internal programming cycle runs, it replaces array data with a status byte. The host can then find out that a write has finished early, without waiting out the worst-case programming time. Two polling schemes share that byte. One bit returns the inverse of the matching bit of the last committed write. A second bit flips once for every new read access during programming.

When programming is not running, the block passes array read data through. Its output driver is enabled only while both active-low enables, chip and output, are asserted. The sequencer supplies four things: the busy flag, a commit strobe with the polled data bit of each accepted write, the read enables, and the array data. A write refused by the protection logic is never committed, so it starts no programming and leaves the polling reference unchanged. All outputs are registered and reflect the inputs sampled at the previous clock edge.

Top module: `wcs_readback`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `bus_oe` = 0 and `bus_data` = 0, and the toggle bit is cleared to 0.
- R2: One cycle after `ce_n` and `oe_n` are both sampled low, `bus_oe` is 1. One cycle after either is sampled high, `bus_oe` is 0 and `bus_data` is 0 (high impedance at the pins).
- R3: During a read sampled with `busy` = 1, bit 7 of `bus_data` equals the inverse of `wr_poll_src` from the most recent accepted write (`wr_commit` = 1).
- R4: During programming, bit 6 of `bus_data` takes the opposite value on each new read access, compared with the previous read access.
- R5: A new read access is counted only when the combined read enable becomes active. A read held over many cycles flips bit 6 once, and bit 6 stays constant for the rest of that read.
- R6: Bits 5 down to 0 of `bus_data` are 0 during a read sampled with `busy` = 1.
- R7: During a read sampled with `busy` = 0, `bus_data` equals `array_data` sampled at the same edge.
- R8: A refused write (`wr_commit` = 0 while `wr_poll_src` changes) does not alter the reference bit used by R3.
- R9: Reads while `busy` = 0 do not flip the toggle bit. The toggle bit keeps its value between programming cycles, so the first busy read of a new cycle returns the opposite of the last busy read of the previous cycle.
- R10: Once `busy` falls, a read returns the true array byte, including bit 7 and bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Internal programming cycle in progress |
| wr_commit | input | 1 | Pulse for a write accepted by the protection logic |
| wr_poll_src | input | 1 | Bit 7 of the data of the write being committed |
| array_data | input | 8 | Array read data |
| bus_data | output | 8 | Byte driven to the host data bus |
| bus_oe | output | 1 | Data bus driver enable (0 = high impedance) |

## Verification
Suppose the toggle register holds a wrong value or misses an edge. The first busy read after the fault then shows bit 6 unchanged, one cycle after the enables go low. A held read that flips more than once shows up on the next sampled cycle. If the stored polling bit is stale or has been overwritten by a refused write, bit 7 is wrong on the very first busy read. If the busy select is wrong, array bytes leak while programming is running, or status bytes appear after it has finished. Either case is visible in the first read cycle.

// File: rtl/wcs_pkg.sv
// Shared types for the write-completion status readback block.
package wcs_pkg;
    // Source selected for the bus data register.
    typedef enum logic [1:0] {
        SEL_QUIET  = 2'd0,
        SEL_ARRAY  = 2'd1,
        SEL_STATUS = 2'd2
    } wcs_sel_e;
endpackage

// File: rtl/wcs_read_detect.sv
// Read access detector.
// Combines the two active-low enables into one read request. It also flags
// the first cycle of each read access and the cycles in which a read is held.
// Assumes the enables are already synchronous to clk.
module wcs_read_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_req,
    output logic rd_start,
    output logic rd_held
);
    logic rd_q;

    // Combined read request: both enables asserted.
    always_comb rd_req = !ce_n && !oe_n;

    // Remember the request from the previous cycle, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_req;
    end

    // Classify the current cycle as the start of a read or a held read.
    always_comb begin
        rd_start = rd_req && !rd_q;
        rd_held  = rd_req && rd_q;
    end
endmodule

// File: rtl/wcs_toggle.sv
// Toggle-bit state.
// Flips once at the start of each read access made while busy. Keeps its
// value at all other times, including across programming cycles.
module wcs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_start,
    input  logic rd_held,
    output logic tgl_nxt
);
    logic tgl_q;

    // Value the toggle takes at this edge; used by the output stage.
    always_comb tgl_nxt = tgl_q ^ (busy && rd_start);

    // Store the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= tgl_nxt;
    end

    // R5
    held_read_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_held && !rd_start) |=> $stable(tgl_q));

    // R9
    idle_read_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_start) |=> $stable(tgl_q));
endmodule

// File: rtl/wcs_last_capture.sv
// Polling reference capture.
// Holds the polled data bit of the last write that the protection logic
// accepted. Refused writes never pulse wr_commit, so they cannot update it.
module wcs_last_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_commit,
    input  logic wr_poll_src,
    output logic poll_ref
);
    // Load the reference bit on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)         poll_ref <= 1'b0;
        else if (wr_commit) poll_ref <= wr_poll_src;
    end

    // R8
    refused_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(poll_ref));
endmodule

// File: rtl/wcs_out_stage.sv
// Output stage.
// Forms the status byte, chooses between quiet, array and status bytes, and
// registers the data together with the driver enable. Assumes POLL_BIT and
// TGL_BIT are distinct positions inside DATA_W.
module wcs_out_stage
    import wcs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TGL_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              busy,
    input  logic              tgl_nxt,
    input  logic              poll_ref,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    logic [DATA_W-1:0] status_byte;
    logic [DATA_W-1:0] next_data;
    wcs_sel_e          sel;

    // Place each status bit: polling, toggle, or reserved zero.
    for (genvar i = 0; i < DATA_W; i++) begin : g_status
        if (i == POLL_BIT) begin : g_poll
            always_comb status_byte[i] = !poll_ref;
        end else if (i == TGL_BIT) begin : g_tgl
            always_comb status_byte[i] = tgl_nxt;
        end else begin : g_rsvd
            always_comb status_byte[i] = 1'b0;
        end
    end

    // Choose the byte source for this cycle.
    always_comb begin
        if (!rd_req)   sel = SEL_QUIET;
        else if (busy) sel = SEL_STATUS;
        else           sel = SEL_ARRAY;
    end

    // Multiplex the selected source.
    always_comb begin
        case (sel)
            SEL_ARRAY:  next_data = array_data;
            SEL_STATUS: next_data = status_byte;
            default:    next_data = '0;
        endcase
    end

    // Register the bus data and the driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_data <= '0;
            bus_oe   <= 1'b0;
        end else begin
            bus_data <= next_data;
            bus_oe   <= rd_req;
        end
    end
endmodule

// File: rtl/wcs_readback.sv
// Write-completion status readback, top level.
// While busy, read accesses return a status byte: the inverted polled bit of
// the last accepted write, plus a toggle bit. Otherwise, reads return array
// data. The bus is quiet when the read is not enabled. Outputs are registered,
// with one cycle of latency from the sampled inputs.
module wcs_readback #(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TGL_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic              wr_commit,
    input  logic              wr_poll_src,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    localparam int RSVD_W = (POLL_BIT < TGL_BIT) ? POLL_BIT : TGL_BIT;

    logic rd_req, rd_start, rd_held, tgl_nxt, poll_ref;

    wcs_read_detect i_detect (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .rd_req(rd_req), .rd_start(rd_start), .rd_held(rd_held)
    );

    wcs_toggle i_toggle (
        .clk(clk), .rst_n(rst_n), .busy(busy), .rd_start(rd_start),
        .rd_held(rd_held), .tgl_nxt(tgl_nxt)
    );

    wcs_last_capture i_capture (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit),
        .wr_poll_src(wr_poll_src), .poll_ref(poll_ref)
    );

    wcs_out_stage #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)) i_out (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .busy(busy),
        .tgl_nxt(tgl_nxt), .poll_ref(poll_ref), .array_data(array_data),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    // R2
    read_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |=> bus_oe);

    // R2
    no_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> (!bus_oe && bus_data == '0));

    // R3
    poll_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ce_n && !oe_n && !wr_commit) |=> (bus_data[POLL_BIT] != $past(poll_ref)));

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ce_n && !oe_n) |=> (bus_data[RSVD_W-1:0] == '0));

    // R7
    array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ce_n && !oe_n) |=> (bus_data == $past(array_data)));
endmodule

// File: tb/test_wcs_readback.sv
module test_wcs_readback;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
    logic       wr_commit = 1'b0, wr_poll_src = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] bus_data;
    logic       bus_oe;
    int         checks = 0, errors = 0;
    logic       last_tgl;

    always #4 clk = ~clk;

    wcs_readback i_wcs_readback (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
        .wr_commit(wr_commit), .wr_poll_src(wr_poll_src),
        .array_data(array_data), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Start a read and sample the first output cycle.
    task automatic read_begin(output logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); d = bus_data;
        check("R2 oe", {7'b0, bus_oe}, 8'h01);
    endtask

    task automatic read_end();
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check("R2 quiet", {bus_oe, 7'b0} | bus_data, 8'h00);
    endtask

    task automatic commit(input logic b);
        @(negedge clk); wr_commit = 1'b1; wr_poll_src = b;
        @(negedge clk); wr_commit = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 oe", {7'b0, bus_oe}, 8'h00);
        check("R1 data", bus_data, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_enables();
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); check("R2 ce only", {7'b0, bus_oe}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); check("R2 oe only", {7'b0, bus_oe}, 8'h00);
        oe_n = 1'b1;
    endtask

    task automatic t_array();
        logic [7:0] d;
        array_data = 8'hA5;
        read_begin(d); check("R7 A5", d, 8'hA5);
        array_data = 8'h3C;
        @(negedge clk); check("R7 3C", bus_data, 8'h3C);
        read_end();
    endtask

    task automatic t_busy_poll();
        logic [7:0] d;
        logic       t0;
        commit(1'b0);
        @(negedge clk); busy = 1'b1; array_data = 8'h5A;
        read_begin(d);
        check("R3 bit7", {7'b0, d[7]}, 8'h01);
        check("R6 rsvd", {2'b0, d[5:0]}, 8'h00);
        // First busy read after reset: the toggle flips from 0 to 1.
        check("R4 first", {7'b0, d[6]}, 8'h01);
        t0 = d[6];
        read_end();
        read_begin(d);
        check("R4 flip", {7'b0, d[6]}, {7'b0, ~t0});
        t0 = d[6];
        repeat (3) begin
            @(negedge clk);
            check("R5 held", {7'b0, bus_data[6]}, {7'b0, t0});
        end
        read_end();
        last_tgl = t0;
    endtask

    task automatic t_refused();
        logic [7:0] d;
        @(negedge clk); wr_poll_src = 1'b1;   // refused: no commit
        @(negedge clk);
        read_begin(d);
        check("R8 ref kept", {7'b0, d[7]}, 8'h01);
        last_tgl = d[6];
        read_end();
    endtask

    task automatic t_done_and_next();
        logic [7:0] d;
        @(negedge clk); busy = 1'b0; array_data = 8'h5A;
        read_begin(d); check("R10 true data", d, 8'h5A);
        read_end();
        array_data = 8'hFF;
        read_begin(d); check("R10 true FF", d, 8'hFF);
        read_end();
        commit(1'b1);
        @(negedge clk); busy = 1'b1;
        read_begin(d);
        check("R9 carry", {7'b0, d[6]}, {7'b0, ~last_tgl});
        check("R3 bit7 zero", {7'b0, d[7]}, 8'h00);
        read_end();
        @(negedge clk); busy = 1'b0;
    endtask

    initial begin
        t_reset();
        t_enables();
        t_array();
        t_busy_poll();
        t_refused();
        t_done_and_next();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule